// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads a four-level radix translation tree that sits in memory. Each request carries the address to translate and the page number of the root table that belongs to the requesting process. Two processes that give different roots can therefore see different mappings for the same virtual address. The walker issues one 8-byte entry read per level over a request/response memory port. It stops at the first leaf or invalid entry, then returns either a physical address or a fault.

Three leaf sizes are handled. A walk that reaches the last level maps a 4 KiB page. A third-level entry flagged as huge maps a 2 MiB page, and a second-level entry flagged as huge maps a 1 GiB page. When a walk ends early, the index bits that were not consumed join the page offset, which then grows to 21 or 30 bits. Only one walk is in progress at a time.

All three stream interfaces use valid/ready handshakes. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while the walker is idle. A memory read stays asserted with a fixed address until `mem_req_ready` accepts it. A response is taken whenever `mem_rsp_valid` is high, because at most one read is ever outstanding. A result stays on the outputs, unchanged, until `res_ready` is high in a cycle where `res_valid` is high. While a result waits there, the walker accepts no new request.

Top module: `pt_walker`

## Requirements
- R1: Bits 63:48 of the virtual address have no effect on the reads issued or on the result.
- R2: The entry read at each level has address {table page number (40 b), 9-bit index, 3'b000}. The index is VA[47:39] at level 1, VA[38:30] at level 2, VA[29:21] at level 3 and VA[20:12] at level 4. The level-1 table is the request's root page number, and each later table is the page number taken from the previous entry.
- R3: In an entry, bit 0 is valid, bit 7 is the huge flag and bits 51:12 are the page number. The other bits are ignored.
- R4: A walk that reaches level 4 with valid entries makes exactly four reads. It returns res_paddr = {level-4 page number, VA[11:0]}, res_size = 0 and res_level = 4.
- R5: A valid level-3 entry with the huge flag set ends the walk after three reads. It returns res_paddr = {page number[39:9], VA[20:0]}, res_size = 1 and res_level = 3.
- R6: A valid level-2 entry with the huge flag set ends the walk after two reads. It returns res_paddr = {page number[39:18], VA[29:0]}, res_size = 2 and res_level = 2.
- R7: An entry with the valid bit clear ends the walk at once with res_fault = 1, res_level = the level of that entry (1 to 4), res_paddr = 0 and res_size = 0. No further read is issued.
- R8: A huge flag in a valid level-1 entry is a fault at level 1. A huge flag in a level-4 entry is ignored, and the walk completes as a 4 KiB mapping.
- R9: req_ready is high only when no walk is in progress and no result is pending, so that at most one walk is active.
- R10: While res_valid is high and res_ready is low, res_valid, res_paddr, res_fault, res_level and res_size stay unchanged.
- R11: While mem_req_valid is high and mem_req_ready is low, mem_req_valid and mem_req_addr stay unchanged.
- R12: After reset, req_ready is 1, and mem_req_valid and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root_ppn | input | 40 | Page number of the level-1 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 52 | Physical address, 0 on fault |
| res_fault | output | 1 | Walk ended on a fault |
| res_level | output | 3 | Level (1 to 4) where the walk stopped |
| res_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |

## Verification
The bench focuses on walks that end early. For the 2 MiB and 1 GiB cases it places nonzero bits in the low part of the leaf page number. A design that merged the offset at the wrong width, or kept those page bits, would return a corrupted address. A read counter checks that walks stop exactly where they should: a faulting design that kept reading, or a huge-page walk that descended one level too far, would show the wrong count. The bench also checks the huge flag at each level, ignored at level 4 and faulting at level 1, and it checks faults at levels 1, 2 and 4 for the reported level. Finally, it translates the same address under different root tables and with different upper 16 bits. A design that mixed in VA[63:48] or ignored the root would read from addresses that hold no entries, and would then fault.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_READ = 2'd1,
    WS_WAIT = 2'd2,
    WS_DONE = 2'd3
  } walk_state_e;

  localparam int ENTRY_W       = 64;
  localparam int ENTRY_BYTES   = 8;
  localparam int PTE_VALID_POS = 0;
  localparam int PTE_HUGE_POS  = 7;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PPN_W  = 40,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2,
  parameter int SH_W   = 3
) (
  input  logic [PPN_W-1:0]        table_ppn,
  input  logic [IDX_W*LEVELS-1:0] vpn,
  input  logic [LVL_W-1:0]        lvl,
  output logic [PPN_W+IDX_W+SH_W-1:0] addr
);
  logic [IDX_W-1:0] idx_by_lvl [LEVELS];

  // level 0 (root) uses the most significant slice of the page number
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_by_lvl[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign addr = {table_ppn, idx_by_lvl[lvl], {SH_W{1'b0}}};
endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec
  import pt_walker_pkg::*;
#(
  parameter int PA_W  = 52,
  parameter int OFF_W = 12
) (
  input  logic [ENTRY_W-1:0]    entry,
  output logic                  ent_valid,
  output logic                  ent_huge,
  output logic [PA_W-OFF_W-1:0] ent_ppn
);
  assign ent_valid = entry[PTE_VALID_POS];
  assign ent_huge  = entry[PTE_HUGE_POS];
  assign ent_ppn   = entry[PA_W-1:OFF_W];

  logic unused_bits;
  assign unused_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:PTE_HUGE_POS+1],
                         entry[PTE_HUGE_POS-1:PTE_VALID_POS+1]};
endmodule

// File: rtl/pt_pa_merge.sv
module pt_pa_merge #(
  parameter int PA_W   = 52,
  parameter int VA_W   = 48,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 2
) (
  input  logic [PA_W-OFF_W-1:0] leaf_ppn,
  input  logic [VA_W-1:0]       va,
  input  logic [LVL_W-1:0]      lvl,
  output logic [PA_W-1:0]       pa
);
  logic [PA_W-1:0] cand [LEVELS];
  logic [PA_W-1:0] base;
  logic [PA_W-1:0] va_ext;

  assign base   = {leaf_ppn, {OFF_W{1'b0}}};
  assign va_ext = PA_W'(va);

  // a leaf at level g keeps the unused lower index bits as offset
  for (genvar g = 0; g < LEVELS; g++) begin : g_mrg
    localparam int OW = OFF_W + IDX_W * (LEVELS - 1 - g);
    localparam logic [PA_W-1:0] MASK = (PA_W'(1) << OW) - PA_W'(1);
    assign cand[g] = (base & ~MASK) | (va_ext & MASK);
  end

  assign pa = cand[lvl];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [63:0]           req_vaddr,
  input  logic [PA_W-OFF_W-1:0] req_root_ppn,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [ENTRY_W-1:0]    mem_rsp_data,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [PA_W-1:0]       res_paddr,
  output logic                  res_fault,
  output logic [2:0]            res_level,
  output logic [1:0]            res_size
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int VPN_W = IDX_W * LEVELS;
  localparam int LVL_W = $clog2(LEVELS);
  localparam int SH_W  = $clog2(ENTRY_BYTES);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e      st;
  logic [LVL_W-1:0] lvl;
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] tbl_ppn;

  logic             e_valid, e_huge;
  logic [PPN_W-1:0] e_ppn;
  logic [PA_W-1:0]  leaf_pa;
  logic             is_leaf, is_fault;

  logic unused_va_hi;
  assign unused_va_hi = ^req_vaddr[63:VA_W];

  assign req_ready     = (st == WS_IDLE);
  assign mem_req_valid = (st == WS_READ);
  assign res_valid     = (st == WS_DONE);

  pt_entry_addr #(.PPN_W(PPN_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
                  .LVL_W(LVL_W), .SH_W(SH_W)) u_addr (
    .table_ppn(tbl_ppn),
    .vpn      (va_q[OFF_W +: VPN_W]),
    .lvl      (lvl),
    .addr     (mem_req_addr)
  );

  pt_entry_dec #(.PA_W(PA_W), .OFF_W(OFF_W)) u_dec (
    .entry    (mem_rsp_data),
    .ent_valid(e_valid),
    .ent_huge (e_huge),
    .ent_ppn  (e_ppn)
  );

  pt_pa_merge #(.PA_W(PA_W), .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                .LEVELS(LEVELS), .LVL_W(LVL_W)) u_mrg (
    .leaf_ppn(e_ppn),
    .va      (va_q),
    .lvl     (lvl),
    .pa      (leaf_pa)
  );

  // huge flag is honoured only between the root and the last level
  assign is_fault = !e_valid || (e_huge && lvl == '0);
  assign is_leaf  = (lvl == LAST_LVL) || e_huge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= WS_IDLE;
      lvl       <= '0;
      va_q      <= '0;
      tbl_ppn   <= '0;
      res_paddr <= '0;
      res_fault <= 1'b0;
      res_level <= 3'd0;
      res_size  <= 2'd0;
    end else begin
      case (st)
        WS_IDLE: if (req_valid) begin
          va_q    <= req_vaddr[VA_W-1:0];
          tbl_ppn <= req_root_ppn;
          lvl     <= '0;
          st      <= WS_READ;
        end
        WS_READ: if (mem_req_ready) st <= WS_WAIT;
        WS_WAIT: if (mem_rsp_valid) begin
          if (is_fault) begin
            res_fault <= 1'b1;
            res_paddr <= '0;
            res_size  <= 2'd0;
            res_level <= 3'(lvl) + 3'd1;
            st        <= WS_DONE;
          end else if (is_leaf) begin
            res_fault <= 1'b0;
            res_paddr <= leaf_pa;
            res_size  <= 2'(LAST_LVL - lvl);
            res_level <= 3'(lvl) + 3'd1;
            st        <= WS_DONE;
          end else begin
            tbl_ppn <= e_ppn;
            lvl     <= lvl + 1'b1;
            st      <= WS_READ;
          end
        end
        WS_DONE: if (res_ready) st <= WS_IDLE;
        default: st <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            res_valid,
  input logic            res_ready,
  input logic [PA_W-1:0] res_paddr,
  input logic            res_fault,
  input logic [2:0]      res_level,
  input logic [1:0]      res_size
);
  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) &&
      $stable(res_fault) && $stable(res_level) && $stable(res_size));

  assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_single_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !res_valid);

  assert_fault_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == '0 && res_size == 2'd0 &&
      res_level >= 3'd1 && res_level <= 3'd4);

  assert_giga_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault && res_size == 2'd2 |-> res_level == 3'd2);

  assert_huge_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault && res_size == 2'd1 |-> res_level == 3'd3);

  assert_small_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault && res_size == 2'd0 |-> res_level == 3'd4);

  assert_entry_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_paddr    (res_paddr),
  .res_fault    (res_fault),
  .res_level    (res_level),
  .res_size     (res_size)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [39:0] req_root_ppn = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [51:0] res_paddr;
  logic        res_fault;
  logic [2:0]  res_level;
  logic [1:0]  res_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root_ppn(req_root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_fault(res_fault),
    .res_level(res_level), .res_size(res_size)
  );

  typedef struct {
    logic [51:0] pa;
    logic        flt;
    logic [2:0]  lvl;
    logic [1:0]  sz;
    int          rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] mem [logic [51:0]];
  int          n_cmp = 0, n_bad = 0;
  int          cyc = 0, rd_cnt = 0, rd_base = 0;
  bit          finished = 0;

  // memory model: one outstanding read, answered the next cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_req_ready <= 1'b0;
      res_ready     <= 1'b0;
    end else begin
      mem_req_ready <= (cyc % 4) != 1;
      res_ready     <= (cyc % 3) != 2;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [51:0] eaddr(logic [39:0] ppn, logic [8:0] idx);
    return {ppn, idx, 3'b000};
  endfunction

  function automatic logic [63:0] pte(logic [39:0] ppn, logic huge);
    return {12'h5A0, ppn, 4'hC, huge, 6'h2A, 1'b1};  // ignored bits set (R3)
  endfunction

  function automatic logic [63:0] mk_va(logic [15:0] hi, logic [8:0] a, logic [8:0] b,
                                        logic [8:0] c, logic [8:0] d, logic [11:0] off);
    return {hi, a, b, c, d, off};
  endfunction

  function automatic exp_t mk_exp(logic [51:0] pa, logic flt, logic [2:0] lvl,
                                  logic [1:0] sz, int rd, string tag);
    exp_t e;
    e.pa = pa; e.flt = flt; e.lvl = lvl; e.sz = sz; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic [39:0] root, input exp_t e);
    sb.push_back(e);
    @(negedge clk);
    req_vaddr    = va;
    req_root_ppn = root;
    req_valid    = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      int rd;
      rd = rd_cnt - rd_base;
      rd_base = rd_cnt;
      if (sb.size() == 0) begin
        chk(0, "unexpected result", {12'd0, res_paddr}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (res_paddr !== e.pa || res_fault !== e.flt || res_level !== e.lvl ||
            res_size !== e.sz || rd != e.rd) begin
          n_bad++;
          $display("FAIL %s act pa=%h f=%0d l=%0d s=%0d rd=%0d exp pa=%h f=%0d l=%0d s=%0d rd=%0d",
                   e.tag, res_paddr, res_fault, res_level, res_size, rd,
                   e.pa, e.flt, e.lvl, e.sz, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired with %0d results pending", sb.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] va;
    logic [39:0] p2m, p1g;
    // tree under root 0x100
    mem[eaddr(40'h100, 9'd5)]   = pte(40'h200, 1'b0);
    mem[eaddr(40'h200, 9'd6)]   = pte(40'h300, 1'b0);
    mem[eaddr(40'h300, 9'd7)]   = pte(40'h400, 1'b0);
    mem[eaddr(40'h400, 9'd8)]   = pte(40'hABCDE, 1'b0);
    p2m = 40'h77E1F;
    mem[eaddr(40'h300, 9'd9)]   = pte(p2m, 1'b1);
    p1g = 40'h9C3FF;
    mem[eaddr(40'h200, 9'd10)]  = pte(p1g, 1'b1);
    mem[eaddr(40'h100, 9'd30)]  = pte(40'h500, 1'b1);
    mem[eaddr(40'h400, 9'd12)]  = pte(40'hBEEF, 1'b1);
    // second root: 0x600 leads to its own level-4 table
    mem[eaddr(40'h600, 9'd5)]   = pte(40'h700, 1'b0);
    mem[eaddr(40'h700, 9'd6)]   = pte(40'h800, 1'b0);
    mem[eaddr(40'h800, 9'd7)]   = pte(40'h900, 1'b0);
    mem[eaddr(40'h900, 9'd8)]   = pte(40'h13579, 1'b0);

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R12 req_ready after reset", {63'd0, req_ready}, 64'd1);
    chk(mem_req_valid === 1'b0, "R12 mem_req_valid after reset", {63'd0, mem_req_valid}, 64'd0);
    chk(res_valid === 1'b0, "R12 res_valid after reset", {63'd0, res_valid}, 64'd0);

    va = mk_va(16'hABCD, 9'd5, 9'd6, 9'd7, 9'd8, 12'h345);
    walk(va, 40'h100, mk_exp({40'hABCDE, 12'h345}, 0, 3'd4, 2'd0, 4, "R4 4K walk"));
    va = mk_va(16'h0000, 9'd5, 9'd6, 9'd7, 9'd8, 12'h345);
    walk(va, 40'h100, mk_exp({40'hABCDE, 12'h345}, 0, 3'd4, 2'd0, 4, "R1 top bits zero"));
    va = mk_va(16'hFFFF, 9'd5, 9'd6, 9'd7, 9'd8, 12'hFFF);
    walk(va, 40'h100, mk_exp({40'hABCDE, 12'hFFF}, 0, 3'd4, 2'd0, 4, "R1 top bits ones"));

    va = mk_va(16'h1234, 9'd5, 9'd6, 9'd9, 9'h1AB, 12'hFED);
    walk(va, 40'h100, mk_exp({p2m[39:9], va[20:0]}, 0, 3'd3, 2'd1, 3, "R5 2M leaf"));

    va = mk_va(16'h0000, 9'd5, 9'd10, 9'h155, 9'h0AA, 12'h123);
    walk(va, 40'h100, mk_exp({p1g[39:18], va[29:0]}, 0, 3'd2, 2'd2, 2, "R6 1G leaf"));

    va = mk_va(16'h0, 9'd20, 9'd6, 9'd7, 9'd8, 12'h0);
    walk(va, 40'h100, mk_exp(52'd0, 1, 3'd1, 2'd0, 1, "R7 fault level 1"));
    va = mk_va(16'h0, 9'd5, 9'd11, 9'd7, 9'd8, 12'h0);
    walk(va, 40'h100, mk_exp(52'd0, 1, 3'd2, 2'd0, 2, "R7 fault level 2"));
    va = mk_va(16'h0, 9'd5, 9'd6, 9'd7, 9'd11, 12'h0);
    walk(va, 40'h100, mk_exp(52'd0, 1, 3'd4, 2'd0, 4, "R7 fault level 4"));

    va = mk_va(16'h0, 9'd30, 9'd1, 9'd2, 9'd3, 12'h10);
    walk(va, 40'h100, mk_exp(52'd0, 1, 3'd1, 2'd0, 1, "R8 huge at level 1"));
    va = mk_va(16'h0, 9'd5, 9'd6, 9'd7, 9'd12, 12'hABC);
    walk(va, 40'h100, mk_exp({40'hBEEF, 12'hABC}, 0, 3'd4, 2'd0, 4, "R8 huge ignored at level 4"));

    va = mk_va(16'h7777, 9'd5, 9'd6, 9'd7, 9'd8, 12'h246);
    walk(va, 40'h600, mk_exp({40'h13579, 12'h246}, 0, 3'd4, 2'd0, 4, "R2 second root"));
    walk(va, 40'h601, mk_exp(52'd0, 1, 3'd1, 2'd0, 1, "R2 wrong root faults"));

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R9 idle after all walks", {63'd0, req_ready}, 64'd1);
    chk(res_valid === 1'b0, "R10 no stale result", {63'd0, res_valid}, 64'd0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule